// File: doc/BRIEF.md
# TDM Serial Audio Receiver

This block takes one time-division-multiplexed serial audio line and turns each slot of every frame into a parallel word. The bit clock, frame sync and data come from outside. The block samples them on its own system clock. It finds the chosen bit-clock edge by comparing the bit-clock level against its value one cycle earlier. Each finished word goes into a small receive FIFO together with the 3-bit number of the slot it came from. The reader therefore always knows which channel a word belongs to.

Overflow handling is where the block earns its place. When a word completes and the FIFO has no room, that word is thrown away and a sticky overrun flag is raised. An interrupt follows if receive errors are enabled. The receiver then stops storing anything until the next frame sync. Because of this, the first word stored after recovery is always slot 0. Draining the FIFO in the middle of a frame can never shift later words into the wrong channels.

The controller is a three-state machine:
- HUNT is entered on reset and on soft reset. It waits for a frame sync.
- RECV shifts bits in and stores words.
- DROP is entered from RECV when a word completes while the FIFO is full. It ignores all bits.

A frame sync moves HUNT to RECV and DROP to RECV, and restarts RECV itself. Soft reset moves any state to HUNT.

Top module: `tdm_rx`

## Requirements
- R1: Each slot is SLOT_BITS (default 32) bits, assembled most significant bit first. In normal framing, the bit sampled together with frame sync is the first (most significant) bit of slot 0.
- R2: Slot tags count 0, 1, … up to `cfg_last_slot` and then wrap to 0. `cfg_last_slot` = 7 gives an 8-slot frame, so 256 bit clocks per frame at the default slot width.
- R3: With `cfg_early_fs` = 1, frame sync is sampled one bit before the first bit of slot 0. The bit sampled with it still belongs to the previous slot and completes that slot normally.
- R4: With `cfg_fall_edge` = 0, data and frame sync are sampled on the rising bit-clock edge; with 1, on the falling edge.
- R5: A word that completes while the FIFO is full is discarded and `ovr_flag` is set. The flag stays set until cleared, and words already in the FIFO are untouched.
- R6: After an overrun, nothing is stored until the next frame sync, so the first word stored afterwards carries slot tag 0.
- R7: `irq` is high exactly when `ovr_flag` is set and `cfg_err_ie` is 1.
- R8: A one-cycle pulse on `ovr_clr` clears `ovr_flag`. A new overrun in the same cycle takes priority.
- R9: A frame sync arriving in the middle of a slot restarts counting at slot 0 and discards the partial word.
- R10: A one-cycle pulse on `soft_rst` empties the FIFO and returns to HUNT, where bits are ignored until a frame sync.
- R11: After `rst_n` is released, `rd_valid`, `ovr_flag` and `irq` are 0.
- R12: The FIFO is first-word-fall-through. `rd_data` and `rd_slot` show the oldest entry while `rd_valid` is 1, and `rd_en` removes that entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic and the read port run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, sampled by clk |
| fsync | input | 1 | Frame sync |
| sdin | input | 1 | Serial data |
| cfg_last_slot | input | SLOT_W | Highest slot number in a frame (slots − 1) |
| cfg_early_fs | input | 1 | 1: frame sync comes one bit before slot 0 |
| cfg_fall_edge | input | 1 | 1: sample on the falling bit-clock edge |
| cfg_err_ie | input | 1 | Enables the overrun interrupt |
| soft_rst | input | 1 | Flushes the FIFO and re-hunts for frame sync |
| ovr_clr | input | 1 | Write-one pulse that clears the overrun flag |
| rd_en | input | 1 | Pops the FIFO head |
| rd_valid | output | 1 | FIFO not empty |
| rd_data | output | SLOT_BITS | Head word |
| rd_slot | output | SLOT_W | Slot tag of the head word |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq | output | 1 | Overrun interrupt |

## Verification
The main path is tried with a table of frames that cover both sampling edges, both frame-sync timings and frame lengths of 1, 2, 4 and 8 slots. Each word carries a pattern unique to its frame and slot, so a mistake in edge choice, bit order or slot counting shows up as shifted data or a wrong tag. The early-sync vectors run frames back to back, which tells apart a receiver that treats the sync-carrying bit as the last bit of the previous slot from one that drops that bit.

The overrun test drains the FIFO part-way through a frame. Storing the rest of that frame is what the old channel-rotating behaviour would do, and no word may be stored there. A partial slot cut short by an early sync, and stray bits after a soft reset, check the discard paths.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_RECV,
        ST_DROP
    } rx_state_e;

endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fall_sel,
    output logic smp
);

    logic bclk_q;
    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            bclk_q   <= bclk;
            primed_q <= 1'b1;
        end
    end

    always_comb begin
        if (fall_sel) smp = primed_q && bclk_q && !bclk;
        else          smp = primed_q && !bclk_q && bclk;
    end

endmodule

// File: rtl/tdm_rx_ctrl.sv
module tdm_rx_ctrl
    import tdm_rx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int SLOT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 smp,
    input  logic                 fs,
    input  logic                 sd,
    input  logic                 cfg_early,
    input  logic [SLOT_W-1:0]    cfg_last_slot,
    input  logic                 fifo_full,
    input  logic                 ovr_clr,
    output logic                 push,
    output logic [SLOT_BITS-1:0] push_data,
    output logic [SLOT_W-1:0]    push_slot,
    output logic                 ovr_flag
);

    localparam int CNT_W = $clog2(SLOT_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SLOT_BITS - 1);

    rx_state_e            state_q, state_d;
    logic [CNT_W-1:0]     bit_q, bit_d;
    logic [SLOT_W-1:0]    slot_q, slot_d;
    logic [SLOT_BITS-1:0] sh_q, sh_d;
    logic                 ovr_q, ovr_d;

    logic [SLOT_BITS-1:0] word;
    logic                 last_bit;
    logic                 sync_now;
    logic                 done;
    logic                 ovf;

    assign word     = {sh_q[SLOT_BITS-2:0], sd};
    assign last_bit = (bit_q == LAST_BIT);
    assign sync_now = smp && fs && !cfg_early;
    assign done     = smp && (state_q == ST_RECV) && last_bit && !sync_now;
    assign ovf      = done && fifo_full;

    // state and datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            bit_q   <= '0;
            slot_q  <= '0;
            sh_q    <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            slot_q  <= slot_d;
            sh_q    <= sh_d;
            ovr_q   <= ovr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        slot_d  = slot_q;
        sh_d    = sh_q;
        if (soft_rst) begin
            state_d = ST_HUNT;
            bit_d   = '0;
            slot_d  = '0;
        end else if (smp) begin
            if (sync_now) begin
                state_d = ST_RECV;
                sh_d    = word;
                bit_d   = CNT_W'(1);
                slot_d  = '0;
            end else begin
                unique case (state_q)
                    ST_RECV: begin
                        sh_d = word;
                        if (last_bit) begin
                            bit_d  = '0;
                            slot_d = (slot_q == cfg_last_slot) ? '0 : slot_q + 1'b1;
                            if (fifo_full) state_d = ST_DROP;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end
                    ST_HUNT, ST_DROP: begin
                        state_d = state_q;
                    end
                    default: state_d = ST_HUNT;
                endcase
                if (fs) begin
                    state_d = ST_RECV;
                    bit_d   = '0;
                    slot_d  = '0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        push      = done && !fifo_full;
        push_data = word;
        push_slot = slot_q;
        ovr_flag  = ovr_q;
        if (ovf)          ovr_d = 1'b1;
        else if (ovr_clr) ovr_d = 1'b0;
        else              ovr_d = ovr_q;
    end

endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo #(
    parameter int W     = 35,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_wr, do_rd;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign do_wr   = wr_en && !full && !flush;
    assign do_rd   = rd_en && !empty && !flush;
    assign rd_data = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= adv(wp_q);
            if (do_rd) rp_q <= adv(rp_q);
            unique case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
    parameter int SLOT_BITS  = 32,
    parameter int SLOT_W     = 3,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk,
    input  logic                 fsync,
    input  logic                 sdin,
    input  logic [SLOT_W-1:0]    cfg_last_slot,
    input  logic                 cfg_early_fs,
    input  logic                 cfg_fall_edge,
    input  logic                 cfg_err_ie,
    input  logic                 soft_rst,
    input  logic                 ovr_clr,
    input  logic                 rd_en,
    output logic                 rd_valid,
    output logic [SLOT_BITS-1:0] rd_data,
    output logic [SLOT_W-1:0]    rd_slot,
    output logic                 ovr_flag,
    output logic                 irq
);

    localparam int ENTRY_W = SLOT_W + SLOT_BITS;

    logic                 smp;
    logic                 push;
    logic [SLOT_BITS-1:0] push_data;
    logic [SLOT_W-1:0]    push_slot;
    logic                 fifo_full;
    logic                 fifo_empty;
    logic [ENTRY_W-1:0]   head;

    tdm_rx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .fall_sel (cfg_fall_edge),
        .smp      (smp)
    );

    tdm_rx_ctrl #(
        .SLOT_BITS (SLOT_BITS),
        .SLOT_W    (SLOT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .smp           (smp),
        .fs            (fsync),
        .sd            (sdin),
        .cfg_early     (cfg_early_fs),
        .cfg_last_slot (cfg_last_slot),
        .fifo_full     (fifo_full),
        .ovr_clr       (ovr_clr),
        .push          (push),
        .push_data     (push_data),
        .push_slot     (push_slot),
        .ovr_flag      (ovr_flag)
    );

    tdm_rx_fifo #(
        .W     (ENTRY_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (soft_rst),
        .wr_en   (push),
        .wr_data ({push_slot, push_data}),
        .rd_en   (rd_en),
        .rd_data (head),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    assign rd_valid = !fifo_empty;
    assign rd_data  = head[SLOT_BITS-1:0];
    assign rd_slot  = head[ENTRY_W-1:SLOT_BITS];
    assign irq      = ovr_flag && cfg_err_ie;

endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk #(
    parameter int SLOT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push,
    input logic [SLOT_W-1:0] push_slot,
    input logic [SLOT_W-1:0] cfg_last_slot,
    input logic              fifo_full,
    input logic              ovr_flag,
    input logic              ovr_clr,
    input logic              soft_rst,
    input logic              rd_valid
);

    logic need_zero_q;
    logic ovr_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need_zero_q <= 1'b1;
            ovr_prev_q  <= 1'b0;
        end else begin
            ovr_prev_q <= ovr_flag;
            if (soft_rst || (ovr_flag && !ovr_prev_q)) need_zero_q <= 1'b1;
            else if (push)                             need_zero_q <= 1'b0;
        end
    end

    assert_no_push_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !fifo_full);

    assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_flag) |-> $past(ovr_clr));

    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_slot <= cfg_last_slot));

    assert_resync_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && need_zero_q) |-> (push_slot == '0));

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !rd_valid);

endmodule

bind tdm_rx tdm_rx_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .push          (push),
    .push_slot     (push_slot),
    .cfg_last_slot (cfg_last_slot),
    .fifo_full     (fifo_full),
    .ovr_flag      (ovr_flag),
    .ovr_clr       (ovr_clr),
    .soft_rst      (soft_rst),
    .rd_valid      (rd_valid)
);

// File: tb/tdm_rx_tb.sv
module tdm_rx_tb;

    localparam int SB = 32;
    localparam int SW = 3;

    typedef struct packed {
        logic        fall;
        logic        early;
        logic [2:0]  last;
        logic [1:0]  nfr;
        logic [31:0] base;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 3'd7, 2'd1, 32'hA5A5_0000},
        '{1'b1, 1'b0, 3'd7, 2'd1, 32'h3C3C_1234},
        '{1'b0, 1'b1, 3'd3, 2'd2, 32'h8001_F00F},
        '{1'b1, 1'b1, 3'd1, 2'd2, 32'h5A00_00A5},
        '{1'b0, 1'b0, 3'd0, 2'd3, 32'hC0DE_7E57},
        '{1'b0, 1'b1, 3'd7, 2'd1, 32'h0F0F_9999}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bclk = 1'b0;
    logic          fsync = 1'b0;
    logic          sdin = 1'b0;
    logic [SW-1:0] cfg_last_slot = 3'd7;
    logic          cfg_early_fs = 1'b0;
    logic          cfg_fall_edge = 1'b0;
    logic          cfg_err_ie = 1'b1;
    logic          soft_rst = 1'b0;
    logic          ovr_clr = 1'b0;
    logic          rd_en = 1'b0;
    logic          rd_valid;
    logic [SB-1:0] rd_data;
    logic [SW-1:0] rd_slot;
    logic          ovr_flag;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tdm_rx u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk          (bclk),
        .fsync         (fsync),
        .sdin          (sdin),
        .cfg_last_slot (cfg_last_slot),
        .cfg_early_fs  (cfg_early_fs),
        .cfg_fall_edge (cfg_fall_edge),
        .cfg_err_ie    (cfg_err_ie),
        .soft_rst      (soft_rst),
        .ovr_clr       (ovr_clr),
        .rd_en         (rd_en),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rd_slot       (rd_slot),
        .ovr_flag      (ovr_flag),
        .irq           (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] base, input int f, input int s);
        return base ^ (32'(f) << 24) ^ (32'(s) * 32'h0011_0011) ^ 32'(s);
    endfunction

    task automatic send_bit(input logic f, input logic d);
        @(negedge clk);
        bclk  = cfg_fall_edge;
        fsync = f;
        sdin  = d;
        @(negedge clk);
        @(negedge clk);
        bclk = !cfg_fall_edge;
        @(negedge clk);
    endtask

    task automatic send_range(input logic [31:0] base, input int kf, input int kt);
        int fb;
        fb = (int'(cfg_last_slot) + 1) * SB;
        for (int k = kf; k <= kt; k++) begin
            logic        fsv;
            logic        dv;
            logic [31:0] w;
            int          pos;
            fsv = cfg_early_fs ? (((k + 1) % fb) == 0) : ((k % fb) == 0);
            if (k < 0) begin
                dv = 1'b0;
            end else begin
                pos = k % fb;
                w   = word_of(base, k / fb, pos / SB);
                dv  = w[SB - 1 - (pos % SB)];
            end
            send_bit(fsv, dv);
        end
        @(negedge clk);
        fsync = 1'b0;
    endtask

    task automatic read_expect(input string req, input int s, input logic [31:0] d);
        @(negedge clk);
        check({req, " valid"}, 32'(rd_valid), 32'd1);
        check({req, " slot"}, 32'(rd_slot), 32'(s));
        check({req, " data"}, rd_data, d);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_soft_rst();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 rd_valid after reset", 32'(rd_valid), 32'd0);
        check("R11 ovr_flag after reset", 32'(ovr_flag), 32'd0);
        check("R11 irq after reset", 32'(irq), 32'd0);

        // Table walk: R1 R2 R3 R4 R12
        for (int v = 0; v < 6; v++) begin
            int fb;
            @(negedge clk);
            cfg_fall_edge = VECS[v].fall;
            cfg_early_fs  = VECS[v].early;
            cfg_last_slot = VECS[v].last;
            pulse_soft_rst();
            fb = (int'(VECS[v].last) + 1) * SB;
            send_range(VECS[v].base, VECS[v].early ? -1 : 0, int'(VECS[v].nfr) * fb - 1);
            repeat (4) @(negedge clk);
            for (int f = 0; f < int'(VECS[v].nfr); f++) begin
                for (int s = 0; s <= int'(VECS[v].last); s++) begin
                    read_expect("R1/R2/R3/R4/R12 table", s, word_of(VECS[v].base, f, s));
                end
            end
            check("R12 empty after drain", 32'(rd_valid), 32'd0);
        end

        // Overrun with mid-frame drain: R5 R6 R7 R8
        @(negedge clk);
        cfg_fall_edge = 1'b0;
        cfg_early_fs  = 1'b0;
        cfg_last_slot = 3'd7;
        cfg_err_ie    = 1'b1;
        pulse_soft_rst();
        send_range(32'h1357_9BDF, 0, 255);
        check("R5 no overrun while room", 32'(ovr_flag), 32'd0);
        send_range(32'h1357_9BDF, 256, 256 + 63);
        repeat (4) @(negedge clk);
        check("R5 overrun flag set", 32'(ovr_flag), 32'd1);
        check("R7 irq with enable", 32'(irq), 32'd1);
        for (int s = 0; s < 8; s++) read_expect("R5 stored words kept", s, word_of(32'h1357_9BDF, 0, s));
        send_range(32'h1357_9BDF, 320, 511);
        repeat (4) @(negedge clk);
        check("R6 rest of frame dropped", 32'(rd_valid), 32'd0);
        send_range(32'h1357_9BDF, 512, 767);
        repeat (4) @(negedge clk);
        for (int s = 0; s < 8; s++) read_expect("R6 resync at slot 0", s, word_of(32'h1357_9BDF, 2, s));
        check("R5 flag sticky", 32'(ovr_flag), 32'd1);
        @(negedge clk);
        cfg_err_ie = 1'b0;
        @(negedge clk);
        check("R7 irq masked", 32'(irq), 32'd0);
        cfg_err_ie = 1'b1;
        @(negedge clk);
        check("R7 irq unmasked", 32'(irq), 32'd1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check("R8 flag cleared", 32'(ovr_flag), 32'd0);
        check("R8 irq follows clear", 32'(irq), 32'd0);

        // Mid-slot frame sync: R9
        pulse_soft_rst();
        send_range(32'hDEAD_0001, 0, 9);
        send_range(32'h2468_ACE0, 0, 255);
        repeat (4) @(negedge clk);
        for (int s = 0; s < 8; s++) read_expect("R9 partial discarded", s, word_of(32'h2468_ACE0, 0, s));
        check("R9 no extra word", 32'(rd_valid), 32'd0);

        // Soft reset: R10
        send_range(32'h7777_0000, 0, 255);
        repeat (4) @(negedge clk);
        check("R10 fifo filled", 32'(rd_valid), 32'd1);
        pulse_soft_rst();
        check("R10 flushed", 32'(rd_valid), 32'd0);
        send_range(32'h7777_0000, 1, 100);
        repeat (4) @(negedge clk);
        check("R10 bits ignored before sync", 32'(rd_valid), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule